// File: doc/BRIEF.md
# Auto-Increment Register Access Port

This block gives a small microcontroller a window onto a bank of device registers through two special registers. The controller loads an index register with the number of the device register it wants. It then moves values by writing a data register or by reading back through the index register. Every transfer through the port moves the index on by one, so a run of neighbouring registers can be filled or emptied with one index load followed by back-to-back transfers. A 64-bit pointer, for example, is stored as two writes: the low word goes first and the high word follows.

The index is 12 bits wide. Its top bit picks one of two copies of a double-buffered register, and the 11 bits below it pick one of 2048 registers within that copy. The increment only ever changes the low 11 bits, so a burst stays in the copy that was chosen. On the device side, a write is a one-cycle strobe that comes with an address and a value. A read drives an address, and the device returns the data combinationally in the same cycle.

Top module: `autoinc_reg_port`

## Requirements
- R1: After reset the index is 0x000, and neither the device write strobe nor the device read strobe is active.
- R2: When an index load is requested, the index takes the loaded value at the next clock edge. A load overrides the increment of any transfer in the same cycle, but that transfer still takes place at the old index.
- R3: A data write raises the device write strobe for that cycle, with the device address equal to the current index and the device data equal to the written value. The index then advances by one.
- R4: A read raises the device read strobe, with the device address equal to the current index. The read data equals the device register at that index in the same cycle, and the index then advances by one.
- R5: When a write and a read are requested in the same cycle, only the write is performed, the read strobe stays low, and the index advances exactly once.
- R6: An advance increments index bits 10:0 modulo 2048 and leaves bit 11 unchanged, so 0x7FF advances to 0x000 and 0xFFF advances to 0x800.
- R7: Index bit 11 reaches the device address unchanged. A write with bit 11 = 1 leaves the register with the same low bits and bit 11 = 0 unmodified.
- R8: Two consecutive data writes after one index load at N place the first word at N and the second word at N+1.
- R9: In a cycle with no request, the index holds its value and no device strobe is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idxLoadEn | input | 1 | Load the index register |
| idxLoadVal | input | 12 | Value to load into the index |
| dataWrEn | input | 1 | Write through the data register |
| dataWrVal | input | 32 | Value to write |
| dataRdEn | input | 1 | Read through the index register |
| dataRdVal | output | 32 | Read result for the current index |
| curIdx | output | 12 | Current index (bit 11 is the bank) |
| devWrEn | output | 1 | Device register write strobe |
| devRdEn | output | 1 | Device register read strobe |
| devAddr | output | 12 | Device register address |
| devWrData | output | 32 | Device register write data |
| devRdData | input | 32 | Device register read data (combinational) |

## Verification
Directed bursts of writes followed by reads of the same run show whether the index advances once per transfer and whether the data reaches the intended register. Index loads at 0x7FF and 0xFFF separate a wrap that stays in its bank from one that carries into the bank bit. A write to bank 1 followed by a read of bank 0 at the same low index shows that the two copies are distinct. A long random mix of loads, writes and reads, biased toward the wrap points and including simultaneous write and read and load plus transfer, is checked against a bench model of the index and of the register contents. This mix shows up wrong priorities and double advances.

// File: rtl/autoinc_pkg.sv
package autoinc_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;  // take the loaded index
    logic wr;    // drive a device write this cycle
    logic rd;    // drive a device read this cycle
    logic adv;   // advance the index after this cycle
  } portStrb_t;
endpackage

// File: rtl/autoinc_ctrl.sv
module autoinc_ctrl
  import autoinc_pkg::*;
(
  input  logic      idxLoadEn,
  input  logic      dataWrEn,
  input  logic      dataRdEn,
  output portStrb_t strb
);
  always_comb begin
    strb      = '0;
    strb.load = idxLoadEn;
    // a write wins over a read requested in the same cycle
    strb.wr   = dataWrEn;
    strb.rd   = dataRdEn && !dataWrEn;
    // one advance per performed transfer, unless a load overrides it
    strb.adv  = (dataWrEn || dataRdEn) && !idxLoadEn;
  end
endmodule

// File: rtl/autoinc_datapath.sv
module autoinc_datapath
  import autoinc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrb_t         strb,
  input  logic [ADDR_W-1:0] idxLoadVal,
  input  logic [DATA_W-1:0] dataWrVal,
  output logic [DATA_W-1:0] dataRdVal,
  output logic [ADDR_W-1:0] curIdx,
  output logic              devWrEn,
  output logic              devRdEn,
  output logic [ADDR_W-1:0] devAddr,
  output logic [DATA_W-1:0] devWrData,
  input  logic [DATA_W-1:0] devRdData
);
  localparam int IDX_W   = ADDR_W - 1;
  localparam int BANK_BIT = ADDR_W - 1;

  logic [ADDR_W-1:0] idxQ;
  logic [ADDR_W-1:0] idxD;
  logic [IDX_W-1:0]  lowNext;

  assign lowNext = idxQ[IDX_W-1:0] + IDX_W'(1);

  always_comb begin
    idxD = idxQ;
    if (strb.load)     idxD = idxLoadVal;
    else if (strb.adv) idxD = {idxQ[BANK_BIT], lowNext};
  end

  always_ff @(posedge clk) begin
    if (!rstN) idxQ <= '0;
    else       idxQ <= idxD;
  end

  assign curIdx    = idxQ;
  assign devAddr   = idxQ;
  assign devWrEn   = strb.wr;
  assign devRdEn   = strb.rd;
  assign devWrData = dataWrVal;
  assign dataRdVal = devRdData;

  // R2: a load defines the next index
  a_r2_load_taken: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> curIdx == $past(idxLoadVal));

  // R3: a device write without a load moves the low index on by one
  a_r3_write_advance: assert property (@(posedge clk) disable iff (!rstN)
    (devWrEn && !strb.load) |=> curIdx[IDX_W-1:0] == $past(curIdx[IDX_W-1:0]) + IDX_W'(1));

  // R4: a device read without a load moves the low index on by one
  a_r4_read_advance: assert property (@(posedge clk) disable iff (!rstN)
    (devRdEn && !strb.load) |=> curIdx[IDX_W-1:0] == $past(curIdx[IDX_W-1:0]) + IDX_W'(1));

  // R5: never both device strobes
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(devWrEn && devRdEn));

  // R6: the bank bit only changes through a load
  a_r6_bank_kept: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> curIdx[BANK_BIT] == $past(curIdx[BANK_BIT]));

  // R9: an idle cycle leaves the index alone
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !devWrEn && !devRdEn) |=> $stable(curIdx));
endmodule

// File: rtl/autoinc_reg_port.sv
module autoinc_reg_port
  import autoinc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxLoadEn,
  input  logic [ADDR_W-1:0] idxLoadVal,
  input  logic              dataWrEn,
  input  logic [DATA_W-1:0] dataWrVal,
  input  logic              dataRdEn,
  output logic [DATA_W-1:0] dataRdVal,
  output logic [ADDR_W-1:0] curIdx,
  output logic              devWrEn,
  output logic              devRdEn,
  output logic [ADDR_W-1:0] devAddr,
  output logic [DATA_W-1:0] devWrData,
  input  logic [DATA_W-1:0] devRdData
);
  portStrb_t strb;

  autoinc_ctrl ctrl_i (
    .idxLoadEn (idxLoadEn),
    .dataWrEn  (dataWrEn),
    .dataRdEn  (dataRdEn),
    .strb      (strb)
  );

  autoinc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .idxLoadVal (idxLoadVal),
    .dataWrVal  (dataWrVal),
    .dataRdVal  (dataRdVal),
    .curIdx     (curIdx),
    .devWrEn    (devWrEn),
    .devRdEn    (devRdEn),
    .devAddr    (devAddr),
    .devWrData  (devWrData),
    .devRdData  (devRdData)
  );
endmodule

// File: tb/autoinc_reg_port_tb.sv
`timescale 1ns/1ps
module autoinc_reg_port_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          idxLoadEn = 1'b0;
  logic [AW-1:0] idxLoadVal = '0;
  logic          dataWrEn = 1'b0;
  logic [DW-1:0] dataWrVal = '0;
  logic          dataRdEn = 1'b0;
  logic [DW-1:0] dataRdVal;
  logic [AW-1:0] curIdx;
  logic          devWrEn;
  logic          devRdEn;
  logic [AW-1:0] devAddr;
  logic [DW-1:0] devWrData;
  logic [DW-1:0] devRdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] devMem [DEPTH];
  logic [DW-1:0] expMem [DEPTH];
  logic [AW-1:0] expIdx;

  always #2 clk = ~clk;

  autoinc_reg_port dut_i (
    .clk(clk), .rstN(rstN),
    .idxLoadEn(idxLoadEn), .idxLoadVal(idxLoadVal),
    .dataWrEn(dataWrEn), .dataWrVal(dataWrVal),
    .dataRdEn(dataRdEn), .dataRdVal(dataRdVal),
    .curIdx(curIdx),
    .devWrEn(devWrEn), .devRdEn(devRdEn),
    .devAddr(devAddr), .devWrData(devWrData), .devRdData(devRdData)
  );

  function automatic logic [DW-1:0] initVal(input int a);
    return 32'hA5000000 ^ (a * 32'h00010013);
  endfunction

  function automatic logic [AW-1:0] incIdx(input logic [AW-1:0] a);
    return {a[AW-1], a[AW-2:0] + 11'd1};
  endfunction

  // device register model
  assign devRdData = devMem[devAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) devMem[i] <= initVal(i);
    end else if (devWrEn) begin
      devMem[devAddr] <= devWrData;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doOp(input string tag, input logic ld, input logic [AW-1:0] la,
                      input logic wr, input logic [DW-1:0] wd, input logic rd);
    logic [AW-1:0] nextIdx;
    @(negedge clk);
    idxLoadEn = ld; idxLoadVal = la; dataWrEn = wr; dataWrVal = wd; dataRdEn = rd;
    #1;
    if (wr) begin
      chk({tag, " R3 wr strobe"}, 32'(devWrEn), 32'd1);
      chk({tag, " R3 wr addr"}, 32'(devAddr), 32'(expIdx));
      chk({tag, " R3 wr data"}, devWrData, wd);
      if (rd) chk({tag, " R5 rd suppressed"}, 32'(devRdEn), 32'd0);
    end else if (rd) begin
      chk({tag, " R4 rd strobe"}, 32'(devRdEn), 32'd1);
      chk({tag, " R4 rd data"}, dataRdVal, expMem[expIdx]);
    end else begin
      chk({tag, " R9 no strobe"}, 32'({devWrEn, devRdEn}), 32'd0);
    end
    if (wr) expMem[expIdx] = wd;
    nextIdx = ld ? la : ((wr || rd) ? incIdx(expIdx) : expIdx);
    @(posedge clk);
    #1;
    idxLoadEn = 1'b0; dataWrEn = 1'b0; dataRdEn = 1'b0;
    chk({tag, ld ? " R2 index" : " R6 index"}, 32'(curIdx), 32'(nextIdx));
    expIdx = nextIdx;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) expMem[i] = initVal(i);
    expIdx = '0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    // R1 reset state
    chk("R1 index after reset", 32'(curIdx), 32'd0);
    chk("R1 strobes after reset", 32'({devWrEn, devRdEn}), 32'd0);

    // burst write then burst read
    doOp("burst", 1'b1, 12'h005, 1'b0, '0, 1'b0);
    for (int k = 0; k < 3; k++) doOp("burst", 1'b0, '0, 1'b1, 32'h1100 + k, 1'b0);
    chk("R3 index after burst", 32'(curIdx), 32'h008);
    doOp("burst", 1'b1, 12'h005, 1'b0, '0, 1'b0);
    for (int k = 0; k < 3; k++) doOp("burst", 1'b0, '0, 1'b0, '0, 1'b1);

    // R8 64-bit pointer, low then high
    doOp("ptr", 1'b1, 12'h0B0, 1'b0, '0, 1'b0);
    doOp("ptr", 1'b0, '0, 1'b1, 32'hDEAD0001, 1'b0);
    doOp("ptr", 1'b0, '0, 1'b1, 32'h0000BEEF, 1'b0);
    doOp("ptr", 1'b1, 12'h0B0, 1'b0, '0, 1'b0);
    @(negedge clk); #1;
    chk("R8 low word", dataRdVal, 32'hDEAD0001);
    doOp("ptr", 1'b0, '0, 1'b0, '0, 1'b1);
    @(negedge clk); #1;
    chk("R8 high word", dataRdVal, 32'h0000BEEF);

    // R6 wraps
    doOp("wrap0", 1'b1, 12'h7FF, 1'b0, '0, 1'b0);
    doOp("wrap0", 1'b0, '0, 1'b1, 32'h77, 1'b0);
    chk("R6 wrap bank0", 32'(curIdx), 32'h000);
    doOp("wrap1", 1'b1, 12'hFFF, 1'b0, '0, 1'b0);
    doOp("wrap1", 1'b0, '0, 1'b0, '0, 1'b1);
    chk("R6 wrap bank1", 32'(curIdx), 32'h800);

    // R7 banks distinct
    doOp("bank", 1'b1, 12'h810, 1'b0, '0, 1'b0);
    doOp("bank", 1'b0, '0, 1'b1, 32'hB1B1B1B1, 1'b0);
    doOp("bank", 1'b1, 12'h010, 1'b0, '0, 1'b0);
    @(negedge clk); #1;
    chk("R7 bank0 untouched", dataRdVal, initVal(12'h010));

    // R5 write and read together; R2 load with concurrent write
    doOp("both", 1'b0, '0, 1'b1, 32'h5555AAAA, 1'b1);
    chk("R5 single advance", 32'(curIdx), 32'h011);
    doOp("ldwr", 1'b1, 12'h300, 1'b1, 32'h12345678, 1'b0);
    chk("R2 write at old index", expMem[12'h011], 32'h12345678);
    doOp("idle", 1'b0, '0, 1'b0, '0, 1'b0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] la;
      int sel;
      sel = $urandom_range(0, 3);
      la = (sel == 0) ? 12'h7FE : (sel == 1) ? 12'hFFE : AW'($urandom);
      doOp("rand", ($urandom_range(0, 9) == 0), la,
           ($urandom_range(0, 2) == 0), $urandom, ($urandom_range(0, 2) == 0));
    end

    // R3 final register contents match model
    begin
      int bad = 0;
      @(negedge clk);
      for (int i = 0; i < DEPTH; i++) if (devMem[i] !== expMem[i]) bad++;
      chk("R3 final contents mismatches", 32'(bad), 32'd0);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule